// File: doc/BRIEF.md
# Pair-Aware Core Allocator

This block picks free processor cores for a start request in a multicore controller. It keeps one busy bit per core and searches that vector combinationally. Its decision is registered, so the result and the start pulses for the chosen cores appear one clock after the strobe. Cores are grouped into partner pairs whose IDs differ only in the least-significant bit, so the pairs are (2k, 2k+1).

A request can ask for one core or for a partner pair. A single-core request first looks for a free core whose partner is already busy. This keeps fully free pairs intact for later pair requests. If no such core exists, it takes the lowest free core. A pair request takes the lowest pair whose two cores are both free, starts both, and reports the even ID.

Each stop strobe clears the matching busy bit. Any cycle with a stop raises a one-cycle stop event, whether or not the number of available cores changed.

Top module: `core_alloc`

## Requirements
- R1: After reset all busy bits are clear, and `done_o`, `ok_o`, `start_o`, `id_o` and `stop_evt_o` are zero.
- R2: A single-core request (`req_i[4]`=1, `req_i[0]`=0) picks the lowest-ID free core whose partner (ID XOR 1) is busy, if one exists.
- R3: If no free core has a busy partner, a single-core request picks the lowest-ID free core.
- R4: A pair request (`req_i[4]`=1, `req_i[0]`=1) picks the lowest pair k whose cores 2k and 2k+1 are both free. It pulses both of their `start_o` bits and reports `id_o`=2k.
- R5: When no suitable core or pair exists, `done_o`=1 and `ok_o`=0, no `start_o` bit is set, and no busy bit becomes set.
- R6: `done_o`, `ok_o`, `id_o` and `start_o` are valid for exactly one cycle, the cycle after the `start_i` strobe. The granted busy bits are set from that same cycle.
- R7: A stop strobe clears the matching busy bit on the next cycle. `stop_evt_o` pulses in the cycle after any cycle with at least one stop bit, even if that core was not busy.
- R8: The search uses the busy vector from before same-cycle stops. A core that is started and stopped in the same cycle ends busy.
- R9: A `start_i` strobe with `req_i[4]`=0 produces no `done_o` and no start pulse, and leaves the busy vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| req_i | input | 5 | Request bits: [4] any-free allocation, [0] pair select |
| stop_i | input | NCORES | Per-core stop strobes |
| busy_o | output | NCORES | Current busy vector |
| done_o | output | 1 | Result valid pulse |
| ok_o | output | 1 | Allocation succeeded |
| id_o | output | log2(NCORES) | Granted core, or even core of a pair |
| start_o | output | NCORES | Start pulse for each granted core |
| stop_evt_o | output | 1 | Pulse after any stop strobe |

## Verification
The assertions check on every cycle that:
- granted cores were free the cycle before;
- a pair grant is two adjacent cores with an even base;
- a single grant takes a core with a busy partner whenever one existed;
- a failure leaves the vector untouched;
- the busy vector follows the stop and start rule.

They cannot show that the lowest ID was chosen among equal candidates, or that the fallback falls on the right core. The bench shows these by comparing every result against its own reference model, on directed fragmented patterns and on random churn.

// File: rtl/core_alloc.sv
module core_alloc #(
  parameter int NCORES = 8,
  parameter int REQW   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [REQW-1:0]           req_i,
  input  logic [NCORES-1:0]         stop_i,
  output logic [NCORES-1:0]         busy_o,
  output logic                      done_o,
  output logic                      ok_o,
  output logic [$clog2(NCORES)-1:0] id_o,
  output logic [NCORES-1:0]         start_o,
  output logic                      stop_evt_o
);
  localparam int IDW    = $clog2(NCORES);
  localparam int NPAIRS = NCORES / 2;

  logic [NCORES-1:0] busy_q;
  logic              half_hit, any_hit, pair_hit;
  logic [IDW-1:0]    half_id, any_id, pair_id, sel_id;
  logic              alloc, want_pair, sel_ok;
  logic [NCORES-1:0] grant;

  always_comb begin
    half_hit = 1'b0; half_id = '0;
    any_hit  = 1'b0; any_id  = '0;
    pair_hit = 1'b0; pair_id = '0;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (!busy_q[i] && busy_q[i ^ 1]) begin
        half_hit = 1'b1;
        half_id  = IDW'(i);
      end
      if (!busy_q[i]) begin
        any_hit = 1'b1;
        any_id  = IDW'(i);
      end
    end
    for (int k = NPAIRS - 1; k >= 0; k--) begin
      if (!busy_q[2*k] && !busy_q[2*k+1]) begin
        pair_hit = 1'b1;
        pair_id  = IDW'(2 * k);
      end
    end
  end

  assign alloc     = start_i && req_i[4];
  assign want_pair = req_i[0];
  assign sel_ok    = want_pair ? pair_hit : (half_hit || any_hit);
  assign sel_id    = want_pair ? pair_id : (half_hit ? half_id : any_id);
  assign grant     = !(alloc && sel_ok) ? '0 :
                     want_pair ? (NCORES'(3) << sel_id) : (NCORES'(1) << sel_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= '0;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      id_o       <= '0;
      start_o    <= '0;
      stop_evt_o <= 1'b0;
    end else begin
      busy_q     <= (busy_q & ~stop_i) | grant;
      done_o     <= alloc;
      ok_o       <= alloc && sel_ok;
      id_o       <= (alloc && sel_ok) ? sel_id : '0;
      start_o    <= grant;
      stop_evt_o <= |stop_i;
    end
  end

  assign busy_o = busy_q;
endmodule

module core_alloc_chk #(
  parameter int NCORES = 8,
  parameter int REQW   = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start_i,
  input logic [REQW-1:0]           req_i,
  input logic [NCORES-1:0]         stop_i,
  input logic [NCORES-1:0]         busy_o,
  input logic                      done_o,
  input logic                      ok_o,
  input logic [$clog2(NCORES)-1:0] id_o,
  input logic [NCORES-1:0]         start_o,
  input logic                      stop_evt_o
);
  logic [NCORES-1:0] pbusy, pstop, swapped;
  logic              ppair, pref_avail;

  always_comb
    for (int i = 0; i < NCORES; i++) swapped[i] = busy_o[i ^ 1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pbusy <= '0; pstop <= '0; ppair <= 1'b0; pref_avail <= 1'b0;
    end else begin
      pbusy <= busy_o; pstop <= stop_i; ppair <= req_i[0];
      pref_avail <= |(~busy_o & swapped);
    end
  end

  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ok_o |-> ((start_o & pbusy) == '0) && ((busy_o & start_o) == start_o)); // R6
  AST_SINGLE_PREF: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ok_o && !ppair && pref_avail |-> pbusy[id_o ^ 1'b1]); // R2
  AST_PAIR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ok_o && ppair |-> !id_o[0] && $countones(start_o) == 2 && start_o[id_o | 1'b1]); // R4
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !ok_o |-> start_o == '0 && busy_o == (pbusy & ~pstop)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> start_o == '0 && !ok_o); // R9
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    |stop_i |=> stop_evt_o); // R7
  AST_BUSY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == ((pbusy & ~pstop) | start_o)); // R8
endmodule

bind core_alloc core_alloc_chk #(.NCORES(NCORES), .REQW(REQW)) u_chk (.*);

// File: tb/tb_core_alloc.sv
module tb_core_alloc;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [4:0] req_i = '0;
  logic [N-1:0] stop_i = '0, busy_o, start_o;
  logic done_o, ok_o, stop_evt_o;
  logic [2:0] id_o;
  int checks = 0, fails = 0;
  logic [N-1:0] mbusy = '0;

  always #2 clk = ~clk;

  core_alloc dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void pick(input logic [N-1:0] b, input logic pair,
                               output logic ok, output int id, output logic [N-1:0] m);
    ok = 0; id = 0; m = '0;
    if (pair) begin
      for (int k = 0; k < N/2 && !ok; k++)
        if (!b[2*k] && !b[2*k+1]) begin ok = 1; id = 2*k; m = N'(3) << id; end
    end else begin
      for (int i = 0; i < N && !ok; i++)
        if (!b[i] && b[i^1]) begin ok = 1; id = i; end
      for (int i = 0; i < N && !ok; i++)
        if (!b[i]) begin ok = 1; id = i; end
      if (ok) m = N'(1) << id;
    end
  endfunction

  task automatic step(logic s, logic [4:0] r, logic [N-1:0] st);
    logic ok, dn, half; int id; logic [N-1:0] m; string tag;
    start_i = s; req_i = r; stop_i = st;
    dn = s && r[4];
    pick(mbusy, r[0], ok, id, m);
    half = |(~mbusy & {mbusy[6],mbusy[7],mbusy[4],mbusy[5],mbusy[2],mbusy[3],mbusy[0],mbusy[1]});
    if (!dn) begin ok = 0; id = 0; m = '0; end
    tag = !dn ? "R9" : !ok ? "R5" : r[0] ? "R4" : half ? "R2" : "R3";
    mbusy = (mbusy & ~st) | m;
    @(posedge clk); @(negedge clk);
    chk({tag, " done R6"}, done_o, dn);
    chk({tag, " ok"}, ok_o, ok);
    chk({tag, " start"}, start_o, m);
    if (ok) chk({tag, " id"}, id_o, id);
    chk((st & m) != 0 ? "R8 busy" : "R7 busy", busy_o, mbusy);
    chk("R7 stop event", stop_evt_o, |st);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0); chk("R1 ok", ok_o, 0);
    chk("R1 start", start_o, 0); chk("R1 evt", stop_evt_o, 0); chk("R1 id", id_o, 0);
    rst_n = 1'b1;
    step(1, 5'h10, 0);   // R3 core0
    step(1, 5'h10, 0);   // R2 core1
    step(1, 5'h11, 0);   // R4 pair at 2
    step(1, 5'h10, 0);   // R3 core4
    step(1, 5'h10, 8'h01); // R2 core5 with stop on core0
    step(1, 5'h10, 0);   // R2 core0
    step(1, 5'h11, 0);   // R4 pair at 6
    step(1, 5'h10, 0);   // R5 full
    step(1, 5'h11, 0);   // R5 pair full
    step(1, 5'h10, 8'h08); // R5 then stop core3
    step(1, 5'h10, 8'h08); // R8 start and stop core3 together
    step(1, 5'h01, 8'h00); // R9 no any-free bit
    step(0, 5'h10, 8'h10); // R7 stop core4
    step(0, 5'h00, 8'h10); // R7 stop of an idle core still pulses
    step(1, 5'h11, 0);   // R5 no free pair
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic s; logic [4:0] r; logic [N-1:0] st;
      s  = ($urandom % 10) < 6;
      r  = 5'($urandom);
      if (($urandom % 10) != 0) r[4] = 1'b1;
      st = (($urandom % 10) < 3) ? (N'(1) << ($urandom % N)) : '0;
      step(s, r, st);
    end
    step(0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule